// File: doc/BRIEF.md
# Linked-Descriptor Sample DMA Engine

This block moves 24-bit samples between a DSP-side word memory and a sample buffer under the control of descriptors kept in a local data memory. Software places one or more seven-word descriptors in that memory. It writes the address of the first one into a link pointer register, then writes a start command. The engine reads a whole descriptor over a read port with one cycle of latency. It then copies the requested number of samples and, unless the descriptor closes the chain, follows the link to the next descriptor.

A descriptor carries, from word 0 to word 6: the link to the next descriptor with its end-of-chain flag in bit 14, a control word whose bit 0 selects the direction, the sample count, the DSP start address, and then the buffer offset, base and size. The engine does not use the last three words for its own addressing. It passes them to an external address generator together with a running sample index, and that generator turns them into a buffer address. When the flagged descriptor has been processed, the engine goes idle and raises a sticky end-of-chain status bit, which is also driven out as an interrupt line.

Top module: `dsp_chain_dma`

## Requirements
- R1: A started fetch issues seven reads on the descriptor port at consecutive addresses beginning at the link pointer. The first read is driven in the cycle right after the start write's clock edge. Read data returns one cycle after the address. The words are taken in the order link, control, count, DSP start address, buffer offset, buffer base, buffer size.
- R2: The register window decodes two address bits. Offset 0 is the link pointer in the low AW bits. Offset 1 reads the busy flag in bit 0. Offset 2 reads the end-of-chain status in bit 7. Offset 3 reads zero. After reset all four read zero.
- R3: A write to offset 1 with bit 0 set starts the engine if it is idle, and busy reads 1 from the next cycle. While the engine is busy such writes are ignored, and no second fetch results.
- R4: A descriptor with count N>0 moves exactly N samples. For sample i there is one read cycle and, in the following cycle, one write cycle of the data just read. The DSP address is word 3 plus i (low DAW bits), and the buffer index is i.
- R5: Control bit 0 = 0 reads the DSP side and writes the buffer side. Bit 0 = 1 reads the buffer side and writes the DSP side. The source side is never written.
- R6: A count of zero produces no data strobes. For a single end-of-chain descriptor with count zero, busy clears on the 10th clock edge after the start edge.
- R7: When bit 14 of word 0 is clear, the next descriptor is fetched from the low AW bits of word 0. After every descriptor, the link pointer register holds those low AW bits.
- R8: When bit 14 of word 0 is set, no further descriptor is fetched after that one. Busy clears and the end-of-chain status is set on the same clock edge.
- R9: The end-of-chain status stays set until a write to offset 2 has bit 7 set. Writes to offset 2 with bit 7 clear leave it unchanged.
- R10: Writes to offset 0 while busy leave the link pointer unchanged.
- R11: During data movement, the address-generator outputs show descriptor words 4, 5 and 6 (offset, base, size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register window write strobe |
| reg_addr | input | 2 | Register window offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on reg_addr) |
| dm_rd_en | output | 1 | Descriptor memory read enable |
| dm_addr | output | AW | Descriptor memory word address |
| dm_rdata | input | DW | Descriptor memory read data, one cycle after address |
| dsp_rd_en | output | 1 | DSP-side read enable |
| dsp_wr_en | output | 1 | DSP-side write enable |
| dsp_addr | output | DAW | DSP-side word address |
| dsp_wdata | output | DW | DSP-side write data |
| dsp_rdata | input | DW | DSP-side read data, one cycle after address |
| buf_rd_en | output | 1 | Buffer-side read enable |
| buf_wr_en | output | 1 | Buffer-side write enable |
| buf_index | output | DW | Sample index within the current descriptor |
| buf_wdata | output | DW | Buffer-side write data |
| buf_rdata | input | DW | Buffer-side read data, one cycle after index |
| ag_offset | output | DW | Descriptor word 4 for the address generator |
| ag_base | output | DW | Descriptor word 5 for the address generator |
| ag_size | output | DW | Descriptor word 6 for the address generator |
| busy | output | 1 | Engine is walking a chain |
| irq | output | 1 | Sticky end-of-chain status |

## Verification
If the start write lands on clock edge E, busy and the first descriptor read are due in the cycle after E. The descriptor words are captured by E+8 and the first sample read follows edge E+9. Each sample then takes two cycles, and the end of chain shows two edges after the last write edge, or at E+10 when the count is zero. The bench drives its register writes on falling edges and checks the first-read and zero-count cases at those exact falling edges. For longer runs it waits on busy with a bounded poll and then compares memory images, strobe counts and captured address-generator values against values it computes from the descriptors it wrote.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

   // descriptor geometry: word order is decoded by the fetch unit and sequencer
   localparam int DESC_LEN     = 7;
   localparam int W_LINK       = 0;
   localparam int W_CTRL       = 1;
   localparam int W_COUNT      = 2;
   localparam int W_DSPA       = 3;
   localparam int W_OFFS       = 4;
   localparam int W_BASE       = 5;
   localparam int W_SIZE       = 6;
   localparam int LINK_END_BIT = 14;
   localparam int STAT_END_BIT = 7;

   // register window offsets
   localparam logic [1:0] RA_LINK  = 2'd0;
   localparam logic [1:0] RA_GO    = 2'd1;
   localparam logic [1:0] RA_STAT  = 2'd2;
   localparam logic [1:0] RA_SPARE = 2'd3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_MOVE,
      SQ_NEXT
   } seq_t;

   typedef enum logic [1:0] {
      MV_IDLE,
      MV_READ,
      MV_WRITE
   } mv_t;

endpackage

// File: rtl/dcx_regwin.sv
module dcx_regwin
   import dcx_pkg::*;
#(
   parameter int DW = 24,
   parameter int AW = 12
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          busy,
   input  logic          link_load,
   input  logic [AW-1:0] link_next,
   input  logic          end_set,
   output logic [AW-1:0] link_ptr,
   output logic          go_req,
   output logic          irq
);

   logic wr_link, wr_go, wr_stat, stat_clear;
   logic unused_wdata;

   assign wr_link    = reg_wr && (reg_addr == RA_LINK);
   assign wr_go      = reg_wr && (reg_addr == RA_GO);
   assign wr_stat    = reg_wr && (reg_addr == RA_STAT);
   assign stat_clear = wr_stat && reg_wdata[STAT_END_BIT];
   assign go_req     = wr_go && reg_wdata[0] && !busy;
   assign unused_wdata = ^reg_wdata;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_LINK:  reg_rdata = DW'(link_ptr);
         RA_GO:    reg_rdata = DW'(busy);
         RA_STAT:  reg_rdata[STAT_END_BIT] = irq;
         default:  reg_rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_ptr <= '0;
         irq      <= 1'b0;
      end else begin
         if (link_load)
            link_ptr <= link_next;
         else if (wr_link && !busy)
            link_ptr <= reg_wdata[AW-1:0];

         if (end_set)
            irq <= 1'b1;
         else if (stat_clear)
            irq <= 1'b0;
      end
   end

   // R9: status is sticky unless explicitly cleared
   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_clear) |=> irq);

   // R10: software cannot move the pointer during a run
   p_link_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !link_load) |=> $stable(link_ptr));

endmodule

// File: rtl/dcx_desc_fetch.sv
module dcx_desc_fetch
   import dcx_pkg::*;
#(
   parameter int DW         = 24,
   parameter int AW         = 12,
   parameter bit PIPE_FETCH = 1'b1
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         launch,
   input  logic [AW-1:0]                start_addr,
   output logic                         dm_rd_en,
   output logic [AW-1:0]                dm_addr,
   input  logic [DW-1:0]                dm_rdata,
   output logic [DESC_LEN-1:0][DW-1:0]  words,
   output logic                         done
);

   localparam int              CNTW = $clog2(DESC_LEN + 1);
   localparam logic [CNTW-1:0] FULL = CNTW'(DESC_LEN);
   localparam logic [CNTW-1:0] LAST = CNTW'(DESC_LEN - 1);

   logic            active, pend, issue_ok;
   logic [CNTW-1:0] iss, cap;
   logic [AW-1:0]   base_q;

   generate
      if (PIPE_FETCH) begin : g_pipe
         assign issue_ok = 1'b1;
      end else begin : g_serial
         assign issue_ok = !pend;
      end
   endgenerate

   assign dm_rd_en = active && (iss != FULL) && issue_ok;
   assign dm_addr  = base_q + AW'(iss);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pend   <= 1'b0;
         iss    <= '0;
         cap    <= '0;
         base_q <= '0;
         done   <= 1'b0;
         words  <= '0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            active <= 1'b1;
            pend   <= 1'b0;
            iss    <= '0;
            cap    <= '0;
            base_q <= start_addr;
         end else if (active) begin
            pend <= dm_rd_en;
            if (dm_rd_en)
               iss <= iss + 1'b1;
            if (pend) begin
               words[cap] <= dm_rdata;
               cap        <= cap + 1'b1;
               if (cap == LAST) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end
         end
      end
   end

   // R1: a finished fetch has issued and captured exactly one descriptor
   p_fetch_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (iss == FULL && cap == FULL && !dm_rd_en));

endmodule

// File: rtl/dcx_mover.sv
module dcx_mover
   import dcx_pkg::*;
#(
   parameter int DW  = 24,
   parameter int DAW = 12
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic           dir,
   input  logic [DW-1:0]  count,
   input  logic [DAW-1:0] dsp_start,
   output logic           dsp_rd_en,
   output logic           dsp_wr_en,
   output logic [DAW-1:0] dsp_addr,
   output logic [DW-1:0]  dsp_wdata,
   input  logic [DW-1:0]  dsp_rdata,
   output logic           buf_rd_en,
   output logic           buf_wr_en,
   output logic [DW-1:0]  buf_index,
   output logic [DW-1:0]  buf_wdata,
   input  logic [DW-1:0]  buf_rdata,
   output logic           done
);

   mv_t            st;
   logic [DW-1:0]  idx, last;
   logic           dir_q;
   logic [DAW-1:0] start_q;
   logic           rd_ph, wr_ph;

   assign rd_ph     = (st == MV_READ);
   assign wr_ph     = (st == MV_WRITE);
   assign dsp_rd_en = rd_ph && !dir_q;
   assign buf_rd_en = rd_ph &&  dir_q;
   assign dsp_wr_en = wr_ph &&  dir_q;
   assign buf_wr_en = wr_ph && !dir_q;
   assign dsp_addr  = start_q + idx[DAW-1:0];
   assign buf_index = idx;
   assign dsp_wdata = buf_rdata;
   assign buf_wdata = dsp_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= MV_IDLE;
         idx     <= '0;
         last    <= '0;
         dir_q   <= 1'b0;
         start_q <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            MV_IDLE: begin
               if (go) begin
                  st      <= MV_READ;
                  idx     <= '0;
                  last    <= count - 1'b1;
                  dir_q   <= dir;
                  start_q <= dsp_start;
               end
            end
            MV_READ:  st <= MV_WRITE;
            MV_WRITE: begin
               if (idx == last) begin
                  st   <= MV_IDLE;
                  done <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= MV_READ;
               end
            end
            default: st <= MV_IDLE;
         endcase
      end
   end

   // R4: one data strobe per cycle at most
   p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dsp_rd_en, dsp_wr_en, buf_rd_en, buf_wr_en}));

   // R4: every read cycle is followed by a write cycle
   p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_rd_en || buf_rd_en) |=> (dsp_wr_en || buf_wr_en));

   // R5: direction steering
   p_dir_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_rd_en |=> buf_wr_en);
   p_dir_rev_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd_en |=> dsp_wr_en);

endmodule

// File: rtl/dsp_chain_dma.sv
module dsp_chain_dma
   import dcx_pkg::*;
#(
   parameter int DW         = 24,
   parameter int AW         = 12,
   parameter int DAW        = 12,
   parameter bit PIPE_FETCH = 1'b1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [1:0]     reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           dm_rd_en,
   output logic [AW-1:0]  dm_addr,
   input  logic [DW-1:0]  dm_rdata,
   output logic           dsp_rd_en,
   output logic           dsp_wr_en,
   output logic [DAW-1:0] dsp_addr,
   output logic [DW-1:0]  dsp_wdata,
   input  logic [DW-1:0]  dsp_rdata,
   output logic           buf_rd_en,
   output logic           buf_wr_en,
   output logic [DW-1:0]  buf_index,
   output logic [DW-1:0]  buf_wdata,
   input  logic [DW-1:0]  buf_rdata,
   output logic [DW-1:0]  ag_offset,
   output logic [DW-1:0]  ag_base,
   output logic [DW-1:0]  ag_size,
   output logic           busy,
   output logic           irq
);

   // elaboration-time parameter checks
   generate
      if (AW > LINK_END_BIT) begin : g_bad_aw
         $error("AW must leave the end-of-chain bit outside the link address");
      end
      if (DW <= LINK_END_BIT) begin : g_bad_dw
         $error("DW must be wide enough to hold the end-of-chain bit");
      end
      if (DAW > DW) begin : g_bad_daw
         $error("DAW must not exceed DW");
      end
   endgenerate

   seq_t                        st;
   logic                        go_req, launch, fetch_done, mv_go, mv_done;
   logic                        link_load, end_set, at_end, zero_cnt;
   logic [AW-1:0]               link_ptr, next_link, launch_addr;
   logic [DESC_LEN-1:0][DW-1:0] words;
   logic                        unused_desc;

   assign next_link   = words[W_LINK][AW-1:0];
   assign at_end      = words[W_LINK][LINK_END_BIT];
   assign zero_cnt    = (words[W_COUNT] == '0);
   assign ag_offset   = words[W_OFFS];
   assign ag_base     = words[W_BASE];
   assign ag_size     = words[W_SIZE];
   assign busy        = (st != SQ_IDLE);
   assign unused_desc = ^{words[W_LINK], words[W_CTRL], words[W_DSPA]};

   always_comb begin
      launch      = 1'b0;
      mv_go       = 1'b0;
      link_load   = 1'b0;
      end_set     = 1'b0;
      launch_addr = link_ptr;
      case (st)
         SQ_IDLE:  launch = go_req;
         SQ_FETCH: mv_go  = fetch_done && !zero_cnt;
         SQ_NEXT: begin
            link_load   = 1'b1;
            end_set     = at_end;
            launch      = !at_end;
            launch_addr = next_link;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SQ_IDLE;
      end else begin
         case (st)
            SQ_IDLE:  if (go_req) st <= SQ_FETCH;
            SQ_FETCH: if (fetch_done) st <= zero_cnt ? SQ_NEXT : SQ_MOVE;
            SQ_MOVE:  if (mv_done) st <= SQ_NEXT;
            SQ_NEXT:  st <= at_end ? SQ_IDLE : SQ_FETCH;
            default:  st <= SQ_IDLE;
         endcase
      end
   end

   dcx_regwin #(.DW(DW), .AW(AW)) u_regwin (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .link_load (link_load),
      .link_next (next_link),
      .end_set   (end_set),
      .link_ptr  (link_ptr),
      .go_req    (go_req),
      .irq       (irq)
   );

   dcx_desc_fetch #(.DW(DW), .AW(AW), .PIPE_FETCH(PIPE_FETCH)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .start_addr (launch_addr),
      .dm_rd_en   (dm_rd_en),
      .dm_addr    (dm_addr),
      .dm_rdata   (dm_rdata),
      .words      (words),
      .done       (fetch_done)
   );

   dcx_mover #(.DW(DW), .DAW(DAW)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (mv_go),
      .dir       (words[W_CTRL][0]),
      .count     (words[W_COUNT]),
      .dsp_start (words[W_DSPA][DAW-1:0]),
      .dsp_rd_en (dsp_rd_en),
      .dsp_wr_en (dsp_wr_en),
      .dsp_addr  (dsp_addr),
      .dsp_wdata (dsp_wdata),
      .dsp_rdata (dsp_rdata),
      .buf_rd_en (buf_rd_en),
      .buf_wr_en (buf_wr_en),
      .buf_index (buf_index),
      .buf_wdata (buf_wdata),
      .buf_rdata (buf_rdata),
      .done      (mv_done)
   );

   // R3: busy holds until the end-of-chain decision
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(st == SQ_NEXT && at_end)) |=> busy);

   // R8: end of chain drops busy and raises status on one edge
   p_end_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_NEXT && at_end) |=> (irq && !busy && !dm_rd_en));

   // R6: a zero count goes straight to the link decision
   p_zero_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_FETCH && fetch_done && zero_cnt) |=> (st == SQ_NEXT && !dsp_rd_en && !buf_rd_en));

endmodule

// File: tb/dsp_chain_dma_bench.sv
module dsp_chain_dma_bench;

   localparam int DW  = 24;
   localparam int AW  = 12;
   localparam int DAW = 12;
   localparam logic [23:0] SENT = 24'hEEEEEE;

   typedef struct packed {
      logic        dir;
      logic [7:0]  cnt;
      logic [11:0] dspa;
      logic [11:0] bbase;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 8'd1, 12'h010, 12'h200},
      '{1'b0, 8'd5, 12'h020, 12'h210},
      '{1'b1, 8'd3, 12'h030, 12'h220},
      '{1'b1, 8'd8, 12'h040, 12'h230},
      '{1'b0, 8'd0, 12'h050, 12'h240},
      '{1'b1, 8'd2, 12'h060, 12'h250}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr = 1'b0;
   logic [1:0]     reg_addr = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic [DW-1:0]  reg_rdata;
   logic           dm_rd_en;
   logic [AW-1:0]  dm_addr;
   logic [DW-1:0]  dm_rdata;
   logic           dsp_rd_en, dsp_wr_en;
   logic [DAW-1:0] dsp_addr;
   logic [DW-1:0]  dsp_wdata, dsp_rdata;
   logic           buf_rd_en, buf_wr_en;
   logic [DW-1:0]  buf_index, buf_wdata, buf_rdata;
   logic [DW-1:0]  ag_offset, ag_base, ag_size;
   logic           busy, irq;

   logic [23:0] dmem [0:4095];
   logic [23:0] dspm [0:4095];
   logic [23:0] bufm [0:4095];
   logic        tb_we = 1'b0;
   logic [1:0]  tb_sel = '0;
   logic [11:0] tb_addr = '0;
   logic [23:0] tb_data = '0;
   logic [11:0] baddr;
   int          n_dm = 0, n_dspw = 0, n_bufw = 0;
   logic [23:0] seen_offs = '0, seen_base = '0, seen_size = '0;
   int          checks = 0, fails = 0;

   always #5 clk = ~clk;

   dsp_chain_dma #(.DW(DW), .AW(AW), .DAW(DAW)) u_dsp_chain_dma (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dm_rd_en(dm_rd_en), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
      .dsp_rd_en(dsp_rd_en), .dsp_wr_en(dsp_wr_en), .dsp_addr(dsp_addr),
      .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
      .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_index(buf_index),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
      .ag_offset(ag_offset), .ag_base(ag_base), .ag_size(ag_size),
      .busy(busy), .irq(irq)
   );

   // bench-side address generator and memories
   assign baddr = 12'(ag_base + buf_index);

   always @(posedge clk) begin
      if (tb_we) begin
         case (tb_sel)
            2'd0:    dmem[tb_addr] <= tb_data;
            2'd1:    dspm[tb_addr] <= tb_data;
            default: bufm[tb_addr] <= tb_data;
         endcase
      end
      if (dm_rd_en) begin dm_rdata <= dmem[dm_addr]; n_dm <= n_dm + 1; end
      if (dsp_rd_en) dsp_rdata <= dspm[dsp_addr];
      if (dsp_wr_en) begin dspm[dsp_addr] <= dsp_wdata; n_dspw <= n_dspw + 1; end
      if (buf_rd_en) buf_rdata <= bufm[baddr];
      if (buf_wr_en) begin bufm[baddr] <= buf_wdata; n_bufw <= n_bufw + 1; end
      if (buf_rd_en || buf_wr_en) begin
         seen_offs <= ag_offset; seen_base <= ag_base; seen_size <= ag_size;
      end
   end

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input int sel, input int addr, input logic [23:0] data);
      tb_sel = 2'(sel); tb_addr = 12'(addr); tb_data = data; tb_we = 1'b1;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic reg_write(input int a, input logic [23:0] d);
      reg_addr = 2'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [23:0] d);
      reg_addr = 2'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic put_desc(input int at, input int link, input bit last, input bit dir,
                           input int cnt, input int dspa, input int offs, input int bbase,
                           input int size);
      poke(0, at,     24'(link) | (last ? 24'h004000 : 24'h0));
      poke(0, at + 1, 24'(dir));
      poke(0, at + 2, 24'(cnt));
      poke(0, at + 3, 24'(dspa));
      poke(0, at + 4, 24'(offs));
      poke(0, at + 5, 24'(bbase));
      poke(0, at + 6, 24'(size));
   endtask

   function automatic logic [23:0] pat(input int seed, input int i);
      return 24'h300000 + 24'(seed * 256) + 24'(i);
   endfunction

   task automatic prep(input bit dir, input int cnt, input int dspa, input int bbase, input int seed);
      for (int i = 0; i <= cnt; i++) begin
         if (i < cnt) poke(dir ? 2 : 1, dir ? bbase + i : dspa + i, pat(seed, i));
         poke(dir ? 1 : 2, dir ? dspa + i : bbase + i, SENT);
      end
   endtask

   task automatic check_data(input bit dir, input int cnt, input int dspa, input int bbase,
                             input int seed, input string tag);
      for (int i = 0; i <= cnt; i++) begin
         logic [23:0] got;
         got = dir ? dspm[12'(dspa + i)] : bufm[12'(bbase + i)];
         chk_eq(tag, 32'(got), (i < cnt) ? 32'(pat(seed, i)) : 32'(SENT));
      end
   endtask

   task automatic wait_idle(input string tag);
      int n;
      n = 0;
      while (busy && n < 3000) begin @(negedge clk); n++; end
      chk_eq(tag, 32'(busy), 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic [23:0] rd;
      int dm0, dw0, bw0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R2)
      for (int a = 0; a < 4; a++) begin
         reg_read(a, rd);
         chk_eq("R2 reset read", 32'(rd), 32'd0);
      end
      chk_eq("R2 reset busy/irq", {30'd0, busy, irq}, 32'd0);
      chk_eq("R1 reset no descriptor read", 32'(dm_rd_en), 32'd0);

      // vector table: single end-of-chain descriptors (R4 R5 R7 R8 R11)
      for (int v = 0; v < 6; v++) begin
         vec_t t;
         int d, lk;
         t  = VECS[v];
         d  = 12'h100 + v * 16;
         lk = 12'h700 + v;
         put_desc(d, lk, 1'b1, t.dir, int'(t.cnt), int'(t.dspa), 5 + v, int'(t.bbase), 24'hFF);
         prep(t.dir, int'(t.cnt), int'(t.dspa), int'(t.bbase), v);
         dm0 = n_dm; dw0 = n_dspw; bw0 = n_bufw;
         reg_write(0, 24'(d));
         reg_write(1, 24'h1);
         wait_idle("R8 vector run ends");
         check_data(t.dir, int'(t.cnt), int'(t.dspa), int'(t.bbase), v, "R4 R5 vector data");
         chk_eq("R1 vector descriptor reads", 32'(n_dm - dm0), 32'd7);
         chk_eq("R4 R5 vector dest writes", 32'(t.dir ? n_dspw - dw0 : n_bufw - bw0), 32'(t.cnt));
         chk_eq("R5 vector source unwritten", 32'(t.dir ? n_bufw - bw0 : n_dspw - dw0), 32'd0);
         chk_eq("R8 vector status", 32'(irq), 32'd1);
         reg_read(0, rd);
         chk_eq("R7 vector link pointer", 32'(rd), 32'(lk));
         if (t.cnt != 0) begin
            chk_eq("R11 offset seen", 32'(seen_offs), 32'(5 + v));
            chk_eq("R11 base seen", 32'(seen_base), 32'(t.bbase));
            chk_eq("R11 size seen", 32'(seen_size), 32'hFF);
         end
         reg_write(2, 24'h80);
      end

      // directed: first-read timing and zero-count end block (R1 R3 R6 R8)
      put_desc(12'h020, 12'h0F0, 1'b1, 1'b0, 0, 12'h300, 0, 12'h300, 0);
      reg_write(0, 24'h020);
      dm0 = n_dm; dw0 = n_dspw; bw0 = n_bufw;
      reg_write(1, 24'h1);
      chk_eq("R1 first read next cycle", {19'd0, dm_rd_en, dm_addr}, {19'd0, 1'b1, 12'h020});
      reg_read(1, rd);
      chk_eq("R3 busy after start", 32'(rd), 32'd1);
      repeat (9) @(negedge clk);
      chk_eq("R6 still busy at edge 9", 32'(busy), 32'd1);
      @(negedge clk);
      chk_eq("R6 R8 idle at edge 10", {30'd0, busy, irq}, 32'd1);
      chk_eq("R6 no data strobes", 32'(n_dspw - dw0 + n_bufw - bw0), 32'd0);
      chk_eq("R1 seven reads", 32'(n_dm - dm0), 32'd7);
      reg_read(2, rd);
      chk_eq("R2 status bit 7", 32'(rd), 32'h80);

      // directed: writes ignored while busy (R3 R10), sticky status (R9)
      put_desc(12'h0A0, 12'h0AA, 1'b1, 1'b0, 6, 12'h420, 0, 12'h520, 0);
      prep(1'b0, 6, 12'h420, 12'h520, 9);
      reg_write(2, 24'h80);
      reg_write(0, 24'h0A0);
      dm0 = n_dm;
      reg_write(1, 24'h1);
      reg_write(0, 24'h300);
      reg_write(1, 24'h1);
      reg_read(0, rd);
      chk_eq("R10 pointer write ignored", 32'(rd), 32'h0A0);
      wait_idle("R3 busy run ends");
      chk_eq("R3 second start ignored", 32'(n_dm - dm0), 32'd7);
      check_data(1'b0, 6, 12'h420, 12'h520, 9, "R4 busy-run data");
      reg_write(2, 24'h000);
      chk_eq("R9 zero write keeps status", 32'(irq), 32'd1);
      reg_write(2, 24'hFFFF7F);
      chk_eq("R9 other bits keep status", 32'(irq), 32'd1);
      reg_write(2, 24'h000080);
      chk_eq("R9 bit 7 clears status", 32'(irq), 32'd0);

      // directed: three-descriptor chain (R7)
      put_desc(12'h040, 12'h060, 1'b0, 1'b0, 2, 12'h400, 1, 12'h500, 7);
      put_desc(12'h060, 12'h080, 1'b0, 1'b1, 0, 12'h408, 2, 12'h508, 7);
      put_desc(12'h080, 12'h0C0, 1'b1, 1'b1, 3, 12'h410, 3, 12'h510, 7);
      prep(1'b0, 2, 12'h400, 12'h500, 11);
      prep(1'b1, 3, 12'h410, 12'h510, 12);
      dm0 = n_dm; dw0 = n_dspw; bw0 = n_bufw;
      reg_write(0, 24'h040);
      reg_write(1, 24'h1);
      wait_idle("R7 chain ends");
      chk_eq("R7 chain descriptor reads", 32'(n_dm - dm0), 32'd21);
      chk_eq("R7 chain buffer writes", 32'(n_bufw - bw0), 32'd2);
      chk_eq("R7 chain dsp writes", 32'(n_dspw - dw0), 32'd3);
      check_data(1'b0, 2, 12'h400, 12'h500, 11, "R7 chain block A");
      check_data(1'b1, 3, 12'h410, 12'h510, 12, "R7 chain block C");
      reg_read(0, rd);
      chk_eq("R7 chain final pointer", 32'(rd), 32'h0C0);
      chk_eq("R8 chain status", 32'(irq), 32'd1);
      reg_read(3, rd);
      chk_eq("R2 spare offset", 32'(rd), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule